// File: doc/BRIEF.md
# Timer-Counter with Watchdog Prescaler Unit

This block pairs an 8-bit timer/counter with an 8-bit watchdog counter, each fed through its own 8-bit prescaler so that either can reach an effective 16-bit span. The instruction clock is derived from the system clock and runs at either half or a quarter of its rate, as set by a clock-option input. The watchdog always counts instruction ticks. The timer counts either instruction ticks or edges on an external count pin, and the edge it counts (rising or falling) is selectable.

Software loads the timer through a write port, and that write also restarts the timer prescaler. A watchdog-clear strobe or a sleep strobe restarts the watchdog counter together with its prescaler. Before edge detection, the external pin passes through a two-flop synchronizer and a stability filter, so a level must persist for one full instruction clock before its edge is taken. Each prescaler divides by 2 to 256, selected by a 3-bit ratio code, or it can be bypassed for divide-by-1. When a counter wraps, it raises a single-cycle pulse.

Top module: `tmr_wdt_unit`

## Requirements
- R1: After reset, the timer value is 0x00, the overflow output is low and the timeout output is low.
- R2: The instruction tick occurs once every 2 system clocks when `clk_div4_i`=0 and once every 4 when it is 1. With the internal source and the prescaler bypassed, the timer advances by one per tick.
- R3: With the timer prescaler in use, ratio code n (0 to 7) advances the timer once per 2^(n+1) counting events.
- R4: A timer write loads `tmr_wdata_i` at that clock edge, overrides any count at the same edge, and clears the timer prescaler.
- R5: The timer wraps from 0xFF to 0x00. `tmr_ovf_o` is high for exactly the one cycle that follows the wrap edge.
- R6: With `tmr_ext_i`=1, the timer counts edges of `tmr_pin_i`: rising edges when `tmr_fall_i`=0 and falling edges when it is 1. The edge of the other direction has no effect.
- R7: A pin level counts only after it has held for at least one instruction clock (2 or 4 system clocks) past the two-flop synchronizer. Shorter pulses have no effect on the timer.
- R8: The watchdog counts instruction ticks through its own prescaler. The prescaler divides by 1 when `wdt_bypass_i`=1 and by 2^(n+1) for ratio code n otherwise. After 256 prescaled ticks the counter wraps and `wdt_tmo_o` pulses high for one cycle.
- R9: `wdt_clr_i` clears the watchdog counter and its prescaler, which restarts the full timeout span.
- R10: `sleep_i` clears the watchdog counter and its prescaler in the same way as `wdt_clr_i`.
- R11: External-pin events pass through the timer prescaler under the same ratio code and bypass rules as internal ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clk_div4_i | input | 1 | Instruction clock option: 0 gives clk/2, 1 gives clk/4 |
| tmr_ext_i | input | 1 | Timer source: 0 internal tick, 1 external pin |
| tmr_fall_i | input | 1 | External edge: 0 rising, 1 falling |
| tmr_bypass_i | input | 1 | 1 bypasses the timer prescaler |
| tmr_ratio_i | input | 3 | Timer prescaler ratio code |
| tmr_wr_i | input | 1 | Timer write strobe |
| tmr_wdata_i | input | 8 | Timer write data |
| wdt_bypass_i | input | 1 | 1 bypasses the watchdog prescaler |
| wdt_ratio_i | input | 3 | Watchdog prescaler ratio code |
| wdt_clr_i | input | 1 | Watchdog-clear strobe |
| sleep_i | input | 1 | Sleep strobe, also clears the watchdog |
| tmr_pin_i | input | 1 | External count pin, asynchronous |
| tmr_value_o | output | 8 | Current timer value |
| tmr_ovf_o | output | 1 | Timer wrap pulse |
| wdt_tmo_o | output | 1 | Watchdog timeout pulse |

## Verification
A prescaler that does not clear on a timer write, or that decodes its ratio code wrongly, shows up as a timer value that is off by one or more at the end of a counting window. The window is one full prescaled period long, and the error appears at the first carry afterwards. A stuck or unfiltered synchronizer becomes visible within a few clocks of a glitch, as an extra count. A wrong edge polarity gives a count of the wrong direction within one instruction clock of the edge. Watchdog faults appear only at the end of a timeout span: either a pulse arrives inside the window where a clear should have held it off, or the pulse is missing one to two clocks after the expected wrap.

// File: rtl/tmr_wdt_unit.sv
module tmr_wdt_unit #(
  parameter int CNT_W = 8,
  parameter int PRE_W = 8,
  localparam int SEL_W = $clog2(PRE_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clk_div4_i,
  input  logic             tmr_ext_i,
  input  logic             tmr_fall_i,
  input  logic             tmr_bypass_i,
  input  logic [SEL_W-1:0] tmr_ratio_i,
  input  logic             tmr_wr_i,
  input  logic [CNT_W-1:0] tmr_wdata_i,
  input  logic             wdt_bypass_i,
  input  logic [SEL_W-1:0] wdt_ratio_i,
  input  logic             wdt_clr_i,
  input  logic             sleep_i,
  input  logic             tmr_pin_i,
  output logic [CNT_W-1:0] tmr_value_o,
  output logic             tmr_ovf_o,
  output logic             wdt_tmo_o
);
  localparam int MW = PRE_W + 1;

  logic [1:0] ph_q;
  logic       tick;
  assign tick = (ph_q == (clk_div4_i ? 2'd3 : 2'd1));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)   ph_q <= '0;
    else if (tick) ph_q <= '0;
    else           ph_q <= ph_q + 2'd1;

  logic [1:0] sync_q;
  logic       pin_d, lvl_q;
  logic [1:0] run_q;
  logic       pin_s, stable, accept, ext_ev;

  assign pin_s  = sync_q[1];
  assign stable = (pin_s == pin_d) && (run_q >= (clk_div4_i ? 2'd3 : 2'd1));
  assign accept = stable && (pin_s != lvl_q);
  assign ext_ev = accept && (tmr_fall_i ? !pin_s : pin_s);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      sync_q <= '0;
      pin_d  <= 1'b0;
      run_q  <= '0;
      lvl_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], tmr_pin_i};
      pin_d  <= pin_s;
      if (pin_s != pin_d)   run_q <= '0;
      else if (run_q != 2'd3) run_q <= run_q + 2'd1;
      if (accept) lvl_q <= pin_s;
    end

  logic [PRE_W-1:0] tps_q, wps_q, tmask, wmask;
  logic [CNT_W-1:0] tmr_q, wdc_q;
  logic             tev, tinc, winc, wclr;

  assign tmask = PRE_W'((MW'(2) << tmr_ratio_i) - MW'(1));
  assign wmask = PRE_W'((MW'(2) << wdt_ratio_i) - MW'(1));
  assign tev   = tmr_ext_i ? ext_ev : tick;
  assign tinc  = tev  && (tmr_bypass_i || ((tps_q & tmask) == tmask));
  assign winc  = tick && (wdt_bypass_i || ((wps_q & wmask) == wmask));
  assign wclr  = wdt_clr_i || sleep_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      tmr_q     <= '0;
      tps_q     <= '0;
      tmr_ovf_o <= 1'b0;
    end else if (tmr_wr_i) begin
      tmr_q     <= tmr_wdata_i;
      tps_q     <= '0;
      tmr_ovf_o <= 1'b0;
    end else begin
      tmr_ovf_o <= tinc && (&tmr_q);
      if (tev && !tmr_bypass_i) tps_q <= tps_q + 1'b1;
      if (tinc) tmr_q <= tmr_q + 1'b1;
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      wdc_q     <= '0;
      wps_q     <= '0;
      wdt_tmo_o <= 1'b0;
    end else if (wclr) begin
      wdc_q     <= '0;
      wps_q     <= '0;
      wdt_tmo_o <= 1'b0;
    end else begin
      wdt_tmo_o <= winc && (&wdc_q);
      if (tick && !wdt_bypass_i) wps_q <= wps_q + 1'b1;
      if (winc) wdc_q <= wdc_q + 1'b1;
    end

  assign tmr_value_o = tmr_q;
endmodule

// File: rtl/tmr_wdt_unit_chk.sv
module tmr_wdt_unit_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tmr_wr_i,
  input logic [CNT_W-1:0] tmr_wdata_i,
  input logic [CNT_W-1:0] tmr_value_o,
  input logic             tmr_ovf_o,
  input logic             wdt_tmo_o,
  input logic             wdt_clr_i,
  input logic             sleep_i
);
  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tmr_wr_i |=> (tmr_value_o == $past(tmr_value_o) ||
                   tmr_value_o == CNT_W'($past(tmr_value_o) + 1'b1)));

  p_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_wr_i |=> tmr_value_o == $past(tmr_wdata_i));

  p_ovf_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_ovf_o |=> !tmr_ovf_o);

  p_ovf_at_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_ovf_o |-> tmr_value_o == '0);

  p_tmo_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_tmo_o |=> !wdt_tmo_o);

  p_clr_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdt_clr_i || sleep_i) |=> !wdt_tmo_o);
endmodule

bind tmr_wdt_unit tmr_wdt_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tmr_wr_i   (tmr_wr_i),
  .tmr_wdata_i(tmr_wdata_i),
  .tmr_value_o(tmr_value_o),
  .tmr_ovf_o  (tmr_ovf_o),
  .wdt_tmo_o  (wdt_tmo_o),
  .wdt_clr_i  (wdt_clr_i),
  .sleep_i    (sleep_i)
);

// File: tb/tb_tmr_wdt_unit.sv
module tb_tmr_wdt_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic div4 = 0, ext = 0, fall = 0, tbyp = 1, wr = 0, wbyp = 1, wclr = 0, slp = 0, pin = 0;
  logic [2:0] trat = 3'd0, wrat = 3'd0;
  logic [7:0] wdata = 8'd0, value;
  logic ovf, tmo;
  int checks = 0, failures = 0, ovf_cnt = 0, tmo_cnt = 0;
  bit ovf_prev = 0, ovf_wide = 0, done = 0;

  always #5 clk = ~clk;

  tmr_wdt_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .clk_div4_i(div4), .tmr_ext_i(ext),
    .tmr_fall_i(fall), .tmr_bypass_i(tbyp), .tmr_ratio_i(trat),
    .tmr_wr_i(wr), .tmr_wdata_i(wdata), .wdt_bypass_i(wbyp),
    .wdt_ratio_i(wrat), .wdt_clr_i(wclr), .sleep_i(slp), .tmr_pin_i(pin),
    .tmr_value_o(value), .tmr_ovf_o(ovf), .wdt_tmo_o(tmo));

  always @(negedge clk) if (rst_n) begin
    if (ovf) ovf_cnt++;
    if (ovf && ovf_prev) ovf_wide = 1;
    ovf_prev = ovf;
    if (tmo) tmo_cnt++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_tmr(input logic [7:0] v);
    wr = 1; wdata = v;
    @(negedge clk);
    wr = 0;
  endtask

  task automatic strobe_clr(input bit use_sleep);
    if (use_sleep) slp = 1; else wclr = 1;
    @(negedge clk);
    slp = 0; wclr = 0;
  endtask

  task automatic pin_pulse(input int hi, input int lo);
    pin = 1; repeat (hi) @(negedge clk);
    pin = 0; repeat (lo) @(negedge clk);
  endtask

  task automatic t_reset;
    check(value == 8'd0, "R1 value", value, 0);
    check(ovf == 1'b0, "R1 ovf", ovf, 0);
    check(tmo == 1'b0, "R1 tmo", tmo, 0);
  endtask

  task automatic t_internal(input bit d4, input bit byp, input logic [2:0] r,
                            input int n, input logic [7:0] st, input string req);
    int l, k, exp;
    ext = 0; div4 = d4; tbyp = byp; trat = r;
    wait_edges(8);
    l = d4 ? 4 : 2;
    k = byp ? 1 : (2 << r);
    wr_tmr(st);
    wait_edges(n * l);
    exp = (st + n / k) % 256;
    check(value == exp[7:0], req, value, exp);
  endtask

  task automatic t_write_clear;
    ext = 0; div4 = 0; tbyp = 0; trat = 3'd2;
    wait_edges(8);
    wr_tmr(8'h10);
    wait_edges(12);
    wr_tmr(8'h10);
    wait_edges(12);
    check(value == 8'h10, "R4 prescaler cleared", value, 16);
    wait_edges(4);
    check(value == 8'h11, "R4 carry after full period", value, 17);
  endtask

  task automatic t_wrap;
    ext = 0; div4 = 0; tbyp = 1;
    wait_edges(8);
    wr_tmr(8'hFE);
    ovf_cnt = 0; ovf_wide = 0;
    wait_edges(8);
    check(value == 8'h02, "R5 wrapped value", value, 2);
    check(ovf_cnt == 1, "R5 overflow pulses", ovf_cnt, 1);
    check(!ovf_wide, "R5 pulse width", ovf_wide, 0);
  endtask

  task automatic t_edges;
    ext = 1; fall = 0; tbyp = 1; div4 = 0; pin = 0;
    wait_edges(8);
    wr_tmr(8'd0);
    repeat (3) pin_pulse(8, 8);
    check(value == 8'd3, "R6 rising edges", value, 3);
    fall = 1;
    wait_edges(8);
    wr_tmr(8'd0);
    pin = 1;
    wait_edges(8);
    check(value == 8'd0, "R6 rising ignored in falling mode", value, 0);
    pin = 0;
    wait_edges(8);
    check(value == 8'd1, "R6 falling counted", value, 1);
  endtask

  task automatic t_filter;
    ext = 1; fall = 0; tbyp = 1; div4 = 0; pin = 0;
    wait_edges(8);
    wr_tmr(8'd0);
    pin_pulse(1, 10);
    check(value == 8'd0, "R7 short pulse div2", value, 0);
    div4 = 1;
    wait_edges(8);
    wr_tmr(8'd0);
    pin_pulse(3, 12);
    check(value == 8'd0, "R7 short pulse div4", value, 0);
    pin_pulse(6, 12);
    check(value == 8'd1, "R7 long pulse div4", value, 1);
    div4 = 0;
  endtask

  task automatic t_ext_pre;
    ext = 1; fall = 0; div4 = 0; pin = 0; tbyp = 0; trat = 3'd0;
    wait_edges(8);
    wr_tmr(8'd0);
    repeat (5) pin_pulse(8, 8);
    check(value == 8'd2, "R11 ext ratio 0", value, 2);
    trat = 3'd1;
    wr_tmr(8'd0);
    repeat (5) pin_pulse(8, 8);
    check(value == 8'd1, "R11 ext ratio 1", value, 1);
    ext = 0; tbyp = 1;
  endtask

  task automatic t_wdt(input bit byp, input int span, input string req);
    div4 = 0; wbyp = byp; wrat = 3'd0;
    wait_edges(4);
    strobe_clr(0);
    tmo_cnt = 0;
    wait_edges(span - 2);
    check(tmo_cnt == 0, {req, " no early timeout"}, tmo_cnt, 0);
    wait_edges(3);
    check(tmo_cnt == 1, {req, " timeout"}, tmo_cnt, 1);
  endtask

  task automatic t_wdt_restart(input bit use_sleep, input string req);
    div4 = 0; wbyp = 1;
    wait_edges(4);
    strobe_clr(0);
    tmo_cnt = 0;
    wait_edges(400);
    strobe_clr(use_sleep);
    wait_edges(509);
    check(tmo_cnt == 0, {req, " restart holds off"}, tmo_cnt, 0);
    wait_edges(3);
    check(tmo_cnt == 1, {req, " timeout after restart"}, tmo_cnt, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_internal(0, 1, 3'd0, 20, 8'd0, "R2 div2");
    t_internal(1, 1, 3'd0, 10, 8'd5, "R2 div4");
    t_internal(0, 0, 3'd0, 7, 8'd0, "R3 ratio 0");
    t_internal(0, 0, 3'd2, 20, 8'd0, "R3 ratio 2");
    t_internal(0, 0, 3'd7, 600, 8'd0, "R3 ratio 7");
    t_write_clear();
    t_wrap();
    t_edges();
    t_filter();
    t_ext_pre();
    t_wdt(1, 512, "R8 bypass");
    t_wdt(0, 1024, "R8 ratio 0");
    t_wdt_restart(0, "R9");
    t_wdt_restart(1, "R10");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule